// File: doc/BRIEF.md
# ADC clock select and result synchronizer

This block wraps the digital part of an 8-bit successive-approximation converter. Software controls it with a power bit and a clock-source bit. The source bit picks either the bus clock or a free-running internal oscillator that is asynchronous to the bus. The chosen clock is switched without glitches onto a single converter clock. That clock drives both the bit-by-bit sequencer and the charge-pump drive output. While the power bit is clear, the converter clock is held low.

Each time power comes on, and each time the source bit changes, a programmable hold-off must run out before a start command is taken. A conversion samples for a fixed number of converter clocks. It then resolves one bit per converter clock, starting from the most significant bit. The analog comparator is modelled as one digital input that answers the trial code the sequencer presents.

The finished code crosses back to the bus domain through a toggle handshake, and the sequencer holds the code stable until the bus side has taken it. In oscillator mode the handshake adds one synchronizer stage. The result register and the completion flag change only on a bus edge where the read-phase input is low, so an update can never land during a read.

Top module: `adc_clk_ctrl`

## Requirements
- R1: After reset, `ready`, `busy` and `done` are 0 and `result` is 0. While `pwr_on` is 0, `cnv_clk` shows no rising edge once the current pulse has ended.
- R2: A start is taken only on a bus edge where `start`, `ready` and not `busy` all hold. A start at any other time leaves `busy` at 0 and starts no conversion.
- R3: Call the first bus edge that samples `pwr_on` high edge 1. After that edge, `ready` stays 0 through bus edge `settle_len` and reads 1 after bus edge `settle_len`+1.
- R4: With `osc_sel`=1, `cnv_clk` follows `clk_osc`. With `osc_sel`=0, it follows `clk_bus`, with one rising edge per bus edge.
- R5: A change of `osc_sel` while powered drops `ready` at once. It then restarts the hold-off with the same counting as in R3, where edge 1 is the first bus edge that samples the new value.
- R6: The comparator input is 1 when the analog input is at or above the `dac_code` on offer. `result` then equals the largest 8-bit code that the comparator accepts, resolved from MSB down to LSB, in either clock mode.
- R7: `result` changes, and `done` rises, only on a bus edge where `rd_phase` is sampled 0. If `rd_phase` stays 1, the update waits.
- R8: `done` goes to 1 together with the result update. It returns to 0 on the bus edge that takes the next start.
- R9: No high or low phase of `cnv_clk` is shorter than the shorter half-period of the two source clocks.
- R10: `busy` is 1 from the edge that takes a start until the result is handed over, and each start that is taken produces exactly one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_osc | input | 1 | Asynchronous internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| pwr_on | input | 1 | Converter power bit |
| osc_sel | input | 1 | Clock source: 1 oscillator, 0 bus clock |
| settle_len | input | SET_W | Hold-off length in bus cycles |
| start | input | 1 | Start a conversion |
| rd_phase | input | 1 | 1 while the bus may be reading results |
| cmp_in | input | 1 | Comparator: analog input at or above dac_code |
| cnv_clk | output | 1 | Converter clock, also the charge-pump drive |
| dac_code | output | DATA_W | Trial code presented to the comparator |
| ready | output | 1 | Powered and settled, so a start may be taken |
| busy | output | 1 | Conversion in flight |
| done | output | 1 | Result register updated since the last start |
| result | output | DATA_W | Converted code |

## Verification
Suppose the sequencer's bit index or code register goes wrong. The error shows as a wrong `result` at the next completion, about twenty bus cycles after the start in bus mode. Suppose a handshake toggle is lost or doubled. Then `busy` stays up and the bench times out, or a second conversion raises `busy` again after `done`. A fault in the clock-gate enables shows within a few cycles, as a missing or extra edge count on `cnv_clk` or a runt pulse on it. A fault in the hold-off counter or the read-phase gating shows on the very edge concerned, as `ready`, `result` or `done` changing one edge early or late.

// File: rtl/adc_pkg.sv
`timescale 1ns/1ps
package adc_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SAMP,
        SQ_CONV,
        SQ_HOLD
    } sq_state_e;

    typedef struct packed {
        logic pwr_q;
        logic sel_q;
    } settle_st_t;

    function automatic logic tgl_differ(input logic a, input logic b);
        return a ^ b;
    endfunction
endpackage

// File: rtl/adc_clk_gmux.sv
`timescale 1ns/1ps
module adc_clk_gmux (
    input  logic clk_bus,
    input  logic clk_osc,
    input  logic rst,
    input  logic pwr_on,
    input  logic osc_sel,
    output logic cnv_clk
);
    logic bus_en1, bus_en2, osc_en1, osc_en2;

    // bus branch runs during reset so the sequencer sees reset edges
    always_ff @(posedge clk_bus)
        bus_en1 <= ~osc_sel & ~osc_en2 & (pwr_on | rst);

    always_ff @(negedge clk_bus)
        bus_en2 <= bus_en1;

    always_ff @(posedge clk_osc)
        if (rst) osc_en1 <= 1'b0;
        else     osc_en1 <= osc_sel & pwr_on & ~bus_en2;

    always_ff @(negedge clk_osc)
        if (rst) osc_en2 <= 1'b0;
        else     osc_en2 <= osc_en1;

    assign cnv_clk = (clk_bus & bus_en2) | (clk_osc & osc_en2);
endmodule

// File: rtl/adc_settle.sv
`timescale 1ns/1ps
module adc_settle
    import adc_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_on,
    input  logic             osc_sel,
    input  logic [SET_W-1:0] settle_len,
    output logic             ready
);
    settle_st_t       st;
    logic [SET_W-1:0] wait_cnt;
    logic             restart;

    assign restart = pwr_on & (~st.pwr_q | (osc_sel ^ st.sel_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            wait_cnt <= '0;
        end else begin
            st.pwr_q <= pwr_on;
            st.sel_q <= osc_sel;
            if (restart)
                wait_cnt <= settle_len;
            else if (wait_cnt != '0)
                wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign ready = pwr_on & st.pwr_q & ~(osc_sel ^ st.sel_q) & (wait_cnt == '0);
endmodule

// File: rtl/adc_sar_seq.sv
`timescale 1ns/1ps
module adc_sar_seq
    import adc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SAMP_CYC = 4
) (
    input  logic              cclk,
    input  logic              rst,
    input  logic              req_tgl,
    input  logic              ack_tgl,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] data,
    output logic              done_tgl
);
    localparam int IW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int SCW = $clog2(SAMP_CYC + 1);

    sq_state_e         state;
    logic [SCW-1:0]    samp_cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] code, code_nx;
    logic              req_s1, req_s2, req_seen, ack_s1, ack_s2;

    always_comb begin
        code_nx      = code;
        code_nx[idx] = cmp_in;
        if (idx != '0)
            code_nx[idx - 1'b1] = 1'b1;
    end

    always_ff @(posedge cclk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            samp_cnt <= '0;
            idx      <= '0;
            code     <= '0;
            data     <= '0;
            done_tgl <= 1'b0;
            req_s1   <= 1'b0;
            req_s2   <= 1'b0;
            req_seen <= 1'b0;
            ack_s1   <= 1'b0;
            ack_s2   <= 1'b0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            unique case (state)
                SQ_IDLE: if (tgl_differ(req_s2, req_seen)) begin
                    req_seen <= req_s2;
                    samp_cnt <= SCW'(SAMP_CYC - 1);
                    code     <= '0;
                    state    <= SQ_SAMP;
                end
                SQ_SAMP: if (samp_cnt == '0) begin
                    code  <= {1'b1, {(DATA_W-1){1'b0}}};
                    idx   <= IW'(DATA_W - 1);
                    state <= SQ_CONV;
                end else begin
                    samp_cnt <= samp_cnt - 1'b1;
                end
                SQ_CONV: begin
                    code <= code_nx;
                    if (idx == '0) begin
                        data     <= code_nx;
                        done_tgl <= ~done_tgl;
                        state    <= SQ_HOLD;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                SQ_HOLD: if (!tgl_differ(ack_s2, done_tgl))
                    state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign dac_code = code;
endmodule

// File: rtl/adc_res_xfer.sv
`timescale 1ns/1ps
module adc_res_xfer
    import adc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_sel,
    input  logic              ready,
    input  logic              start,
    input  logic              rd_phase,
    input  logic              done_tgl,
    input  logic [DATA_W-1:0] seq_data,
    output logic              req_tgl,
    output logic              ack_tgl,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    logic [SYNC_N-1:0] chain;
    logic              d_seen, pending, accept;

    generate
        if (SYNC_N > 1) begin : g_chain
            always_ff @(posedge clk)
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_N-2:0], done_tgl};
        end else begin : g_single
            always_ff @(posedge clk)
                if (rst) chain <= '0;
                else     chain <= done_tgl;
        end
    endgenerate

    // oscillator mode takes the full chain; bus mode is already in phase
    assign d_seen  = osc_sel ? chain[SYNC_N-1] : chain[0];
    assign pending = tgl_differ(d_seen, ack_tgl);
    assign busy    = tgl_differ(req_tgl, ack_tgl);
    assign accept  = start & ready & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            ack_tgl <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            if (accept) begin
                req_tgl <= ~req_tgl;
                done    <= 1'b0;
            end
            if (pending && !rd_phase) begin
                result  <= seq_data;
                done    <= 1'b1;
                ack_tgl <= ~ack_tgl;
            end
        end
    end
endmodule

// File: rtl/adc_clk_ctrl.sv
`timescale 1ns/1ps
module adc_clk_ctrl #(
    parameter int DATA_W   = 8,
    parameter int SET_W    = 8,
    parameter int SAMP_CYC = 4,
    parameter int SYNC_N   = 2
) (
    input  logic              clk_bus,
    input  logic              clk_osc,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              osc_sel,
    input  logic [SET_W-1:0]  settle_len,
    input  logic              start,
    input  logic              rd_phase,
    input  logic              cmp_in,
    output logic              cnv_clk,
    output logic [DATA_W-1:0] dac_code,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    logic              req_tgl, ack_tgl, done_tgl;
    logic [DATA_W-1:0] seq_data;

    adc_clk_gmux u_gmux (
        .clk_bus (clk_bus),
        .clk_osc (clk_osc),
        .rst     (rst),
        .pwr_on  (pwr_on),
        .osc_sel (osc_sel),
        .cnv_clk (cnv_clk)
    );

    adc_settle #(.SET_W(SET_W)) u_settle (
        .clk        (clk_bus),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .osc_sel    (osc_sel),
        .settle_len (settle_len),
        .ready      (ready)
    );

    adc_sar_seq #(.DATA_W(DATA_W), .SAMP_CYC(SAMP_CYC)) u_seq (
        .cclk     (cnv_clk),
        .rst      (rst),
        .req_tgl  (req_tgl),
        .ack_tgl  (ack_tgl),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .data     (seq_data),
        .done_tgl (done_tgl)
    );

    adc_res_xfer #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_xfer (
        .clk      (clk_bus),
        .rst      (rst),
        .osc_sel  (osc_sel),
        .ready    (ready),
        .start    (start),
        .rd_phase (rd_phase),
        .done_tgl (done_tgl),
        .seq_data (seq_data),
        .req_tgl  (req_tgl),
        .ack_tgl  (ack_tgl),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );
endmodule

// File: rtl/adc_clk_ctrl_chk.sv
`timescale 1ns/1ps
module adc_clk_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_bus,
    input logic              rst,
    input logic              pwr_on,
    input logic              start,
    input logic              rd_phase,
    input logic              ready,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result
);
    AST_RESULT_NO_READ: assert property (@(posedge clk_bus) disable iff (rst)
        !$stable(result) |-> !$past(rd_phase)); // R7

    AST_DONE_RISE_NO_READ: assert property (@(posedge clk_bus) disable iff (rst)
        $rose(done) |-> !$past(rd_phase)); // R8

    AST_DONE_CLEAR_ON_START: assert property (@(posedge clk_bus) disable iff (rst)
        (start && ready && !busy) |=> !done); // R8

    AST_BUSY_ONLY_ON_TAKEN_START: assert property (@(posedge clk_bus) disable iff (rst)
        $rose(busy) |-> ($past(start) && $past(ready))); // R2

    AST_READY_NEEDS_POWER: assert property (@(posedge clk_bus) disable iff (rst)
        ready |-> $past(pwr_on)); // R3
endmodule

bind adc_clk_ctrl adc_clk_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_bus  (clk_bus),
    .rst      (rst),
    .pwr_on   (pwr_on),
    .start    (start),
    .rd_phase (rd_phase),
    .ready    (ready),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sim_adc_clk_ctrl.sv
`timescale 1ns/1ps
module sim_adc_clk_ctrl;
    logic       clk_bus = 1'b0, clk_osc = 1'b0;
    logic       rst = 1'b1, pwr_on = 1'b0, osc_sel = 1'b0;
    logic [7:0] settle_len = 8'd10;
    logic       start = 1'b0, rd_phase = 1'b0, cmp_in;
    logic       cnv_clk, ready, busy, done;
    logic [7:0] dac_code, result;
    logic [7:0] vin = 8'd0;
    logic       rd_force = 1'b0, rd_rand = 1'b0;
    int         checks = 0, errors = 0;
    int         n_cnv = 0, runt = 0;
    bit         finished = 1'b0;

    always #2.5 clk_bus = ~clk_bus;
    always #3.7 clk_osc = ~clk_osc;

    assign cmp_in = (vin >= dac_code);

    adc_clk_ctrl u0 (
        .clk_bus (clk_bus), .clk_osc (clk_osc), .rst (rst),
        .pwr_on (pwr_on), .osc_sel (osc_sel), .settle_len (settle_len),
        .start (start), .rd_phase (rd_phase), .cmp_in (cmp_in),
        .cnv_clk (cnv_clk), .dac_code (dac_code), .ready (ready),
        .busy (busy), .done (done), .result (result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_bus);
    endtask

    function automatic logic [7:0] exp_sar(input logic [7:0] v);
        logic [7:0] c = 8'd0;
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] t = c | (8'd1 << i);
            if (v >= t) c = t;
        end
        return c;
    endfunction

    // read-phase driver
    initial forever begin
        @(negedge clk_bus);
        rd_phase = rd_force ? 1'b1 : (rd_rand ? 1'($urandom % 2) : 1'b0);
    end

    // converter clock edge counter and pulse width monitor (R9)
    initial forever begin
        @(posedge cnv_clk);
        n_cnv++;
    end
    initial begin
        realtime last = 0.0;
        forever begin
            @(cnv_clk);
            if (last > 0.0 && ($realtime - last) < 2.4) runt++;
            last = $realtime;
        end
    end

    // R7 monitor: result and done rise only after an edge with rd_phase 0
    initial begin
        logic [7:0] pr = 8'd0;
        logic       pd = 1'b0;
        forever begin
            @(posedge clk_bus);
            #1;
            if (!rst) begin
                if (result != pr) chk(!rd_phase, "R7 result moved in read phase", rd_phase, 0);
                if (done && !pd)  chk(!rd_phase, "R7 done rose in read phase", rd_phase, 0);
            end
            pr = result;
            pd = done;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 600) begin
            tick(1);
            n++;
        end
        chk(done, {tag, " timeout"}, done, 1);
    endtask

    task automatic convert(input logic [7:0] v, input string tag);
        vin = v;
        tick(1);
        pulse_start();
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        chk(done == 1'b0, "R8 done cleared on start", done, 0);
        wait_done(tag);
        tick(2);
        chk(result == exp_sar(v), tag, result, exp_sar(v));
        chk(busy == 1'b0, "R10 busy low after handover", busy, 0);
    endtask

    task automatic settle_check(input int len, input string tag);
        tick(len);
        chk(ready == 1'b0, {tag, " ready early"}, ready, 0);
        tick(1);
        chk(ready == 1'b1, {tag, " ready late"}, ready, 1);
    endtask

    initial begin
        int c0;
        void'($urandom(32'h5eed_1234));
        tick(10);
        rst = 1'b0;
        tick(4);
        // R1: reset state, clock gated off
        chk(ready == 0 && busy == 0 && done == 0, "R1 flags after reset", {ready, busy, done}, 0);
        chk(result == 8'd0, "R1 result after reset", result, 0);
        c0 = n_cnv;
        tick(20);
        chk(n_cnv == c0, "R1 cnv_clk idle while unpowered", n_cnv - c0, 0);

        // R2: start without power is ignored
        pulse_start();
        tick(2);
        chk(busy == 1'b0, "R2 start ignored unpowered", busy, 0);

        // R3: power-up hold-off, with a start attempted during it (R2)
        pwr_on = 1'b1;
        tick(3);
        pulse_start();
        tick(settle_len - 4);
        chk(busy == 1'b0, "R2 start ignored while settling", busy, 0);
        chk(ready == 1'b0, "R3 ready early", ready, 0);
        tick(1);
        chk(ready == 1'b1, "R3 ready late", ready, 1);

        // R4: bus-clock mode edge count
        c0 = n_cnv;
        tick(100);
        chk((n_cnv - c0) >= 99 && (n_cnv - c0) <= 101, "R4 bus mode edges", n_cnv - c0, 100);

        // R6: directed corners in bus mode
        convert(8'h00, "R6 bus zero");
        convert(8'hFF, "R6 bus full");
        convert(8'h80, "R6 bus mid");
        convert(8'h7F, "R6 bus below mid");

        // R6/R7: random codes with random read phases
        rd_rand = 1'b1;
        for (int i = 0; i < 8; i++) convert(8'($urandom), "R6 bus random");
        rd_rand = 1'b0;

        // R7: held read phase stalls the update
        vin = 8'h3C;
        rd_force = 1'b1;
        tick(1);
        pulse_start();
        c0 = int'(result);
        tick(100);
        chk(done == 1'b0, "R7 done held during read", done, 0);
        chk(int'(result) == c0, "R7 result held during read", result, c0);
        rd_force = 1'b0;
        wait_done("R7 release");
        tick(1);
        chk(result == 8'h3C, "R7 result after release", result, 8'h3C);

        // R10: start while busy gives one conversion only
        vin = 8'h5A;
        tick(1);
        pulse_start();
        tick(2);
        pulse_start();
        wait_done("R10 single");
        tick(60);
        chk(busy == 1'b0 && done == 1'b1, "R10 no second conversion", {busy, done}, 1);
        chk(result == 8'h5A, "R10 result", result, 8'h5A);

        // R5: switch to oscillator, hold-off restarts
        settle_len = 8'd12;
        osc_sel = 1'b1;
        #0.1;
        chk(ready == 1'b0, "R5 ready drops on switch", ready, 0);
        settle_check(12, "R5 osc switch");

        // R4: oscillator-mode edge count
        c0 = n_cnv;
        tick(100);
        chk((n_cnv - c0) >= 60 && (n_cnv - c0) <= 75, "R4 osc mode edges", n_cnv - c0, 67);

        convert(8'h00, "R6 osc zero");
        convert(8'hFF, "R6 osc full");
        rd_rand = 1'b1;
        for (int i = 0; i < 6; i++) convert(8'($urandom), "R6 osc random");
        rd_rand = 1'b0;

        // R5: back to bus clock
        osc_sel = 1'b0;
        settle_check(12, "R5 bus switch");
        convert(8'hA5, "R6 bus after switch");

        // R1: power off stops the converter clock
        pwr_on = 1'b0;
        tick(4);
        c0 = n_cnv;
        tick(20);
        chk(n_cnv == c0, "R1 cnv_clk idle after power off", n_cnv - c0, 0);
        chk(ready == 1'b0, "R1 ready low after power off", ready, 0);

        chk(runt == 0, "R9 runt pulses on cnv_clk", runt, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule